// File: doc/BRIEF.md
# Digital Synchronous Demodulator Core

This block drives a sensor with a square-wave excitation and recovers the sensor's response by synchronous demodulation. A free-running binary counter on the master clock divides it down by 1024; the counter's top bit is the excitation pin. The same counter supplies the demodulation reference, so excitation and reference can never drift apart.

Signed samples of the sensor response arrive on a sample bus with a valid strobe. Each accepted sample is multiplied by +1 or -1 according to the reference and is presented one cycle later with its own valid flag. A select bit picks either the reference aligned with the excitation or a copy delayed by a quarter period. The quarter-period copy makes the output sensitive to the quadrature part of the response. A one-cycle strobe marks the start of every reference period, so a downstream averaging filter can align its windows to whole periods. The later low-pass filtering is outside this block.

Top module: `sync_demod_core`

## Requirements
- R1: The excitation `exc_o` is low for the first 512 clock cycles after reset is released, and after that it changes level every 512 cycles. This gives a period of 1024 master-clock cycles with a 50% duty cycle.
- R2: `cyc_stb_o` is high for exactly one cycle each time the internal 10-bit counter wraps from 1023 to 0, which is the cycle in which `exc_o` falls. It does not pulse when reset is released.
- R3: With `quad_sel_i` = 0, a sample accepted while the counter is in 512..1023 (`exc_o` high) is passed unchanged. A sample accepted while the counter is in 0..511 is negated.
- R4: With `quad_sel_i` = 1, the reference is high for counter values 0..255 and 768..1023 and low for 256..767. This is the aligned reference delayed by 256 counts. Samples are passed while the reference is high and negated while it is low.
- R5: Negating the most negative code (0x8000 for 16 bits) gives the largest positive code (0x7FFF). The most negative code is passed unchanged while the reference is high.
- R6: `dem_valid_o` equals `smp_valid_i` delayed by one clock. `dem_data_o` is updated at the same edge, using the counter value present at the edge where the sample was accepted.
- R7: While `smp_valid_i` is low, `dem_data_o` holds its last value.
- R8: Over one full period, an input of +A during the high half of the excitation and -A during the low half averages +A in the aligned mode. The inverted input averages -A. In the quarter-period mode, the in-phase input averages zero, and the output changes sign every 256 samples.
- R9: A synchronous active-high reset clears the counter and drives `exc_o`, `cyc_stb_o`, `dem_valid_o` and `dem_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data_i | input | DATA_W | Signed input sample |
| smp_valid_i | input | 1 | Input sample valid |
| quad_sel_i | input | 1 | 0: aligned reference, 1: quarter-period delayed reference |
| exc_o | output | 1 | Square-wave excitation |
| cyc_stb_o | output | 1 | One-cycle pulse at the start of each reference period |
| dem_data_o | output | DATA_W | Signed demodulated sample |
| dem_valid_o | output | 1 | Demodulated sample valid |

## Verification
The hardest cases to reach from the ports are the reference boundaries, because they occur only once every 256 or 512 cycles. This matters most in the quarter-period mode, where the reference edges do not line up with the visible excitation edges. The bench keeps its own count of cycles since reset and waits until that count reaches 0 before it starts a stream. It then feeds a full 1024-sample period in which every sample is placed at a known counter value, so that every boundary of both reference modes is crossed. The saturation case needs the most negative code to arrive while the reference is low, so the bench waits for a counter window in which the reference is low before it drives that code.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic {
    REF_ALIGNED = 1'b0,
    REF_QUARTER = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/sdm_divider.sv
module sdm_divider #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             exc_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      wrap_q <= (cnt_q == CNT_LAST);
    end
  end

  assign cnt_o  = cnt_q;
  assign exc_o  = cnt_q[CNT_W-1];
  assign wrap_o = wrap_q;
endmodule

// File: rtl/sdm_ref_phaser.sv
module sdm_ref_phaser #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             quad_i,
  output logic             ref_o
);
  import sdm_pkg::*;
  localparam logic [CNT_W-1:0] QUARTER = CNT_W'(1) << (CNT_W - 2);

  logic [CNT_W-1:0] shifted;

  always_comb begin
    shifted = cnt_i - QUARTER;
    if (ref_mode_e'(quad_i) == REF_QUARTER) ref_o = shifted[CNT_W-1];
    else                                    ref_o = cnt_i[CNT_W-1];
  end
endmodule

// File: rtl/sdm_sign_mult.sv
module sdm_sign_mult #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic                     in_valid_i,
  input  logic                     ref_i,
  output logic signed [DATA_W-1:0] out_data_o,
  output logic                     out_valid_o
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] neg_sat;
  logic signed [DATA_W-1:0] product;

  always_comb begin
    if (in_data_i == MOST_NEG) neg_sat = MOST_POS;
    else                       neg_sat = -in_data_i;
    product = ref_i ? in_data_i : neg_sat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= product;
    end
  end
endmodule

// File: rtl/sync_demod_core.sv
module sync_demod_core #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] smp_data_i,
  input  logic                     smp_valid_i,
  input  logic                     quad_sel_i,
  output logic                     exc_o,
  output logic                     cyc_stb_o,
  output logic signed [DATA_W-1:0] dem_data_o,
  output logic                     dem_valid_o
);
  logic [CNT_W-1:0] phase_cnt;
  logic             ref_sign;

  sdm_divider #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (phase_cnt),
    .exc_o (exc_o),
    .wrap_o(cyc_stb_o)
  );

  sdm_ref_phaser #(.CNT_W(CNT_W)) u_ref (
    .cnt_i (phase_cnt),
    .quad_i(quad_sel_i),
    .ref_o (ref_sign)
  );

  sdm_sign_mult #(.DATA_W(DATA_W)) u_mul (
    .clk        (clk),
    .rst        (rst),
    .in_data_i  (smp_data_i),
    .in_valid_i (smp_valid_i),
    .ref_i      (ref_sign),
    .out_data_o (dem_data_o),
    .out_valid_o(dem_valid_o)
  );
endmodule

// File: rtl/sync_demod_chk.sv
module sync_demod_chk #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [DATA_W-1:0] smp_data_i,
  input logic                     smp_valid_i,
  input logic                     quad_sel_i,
  input logic                     exc_o,
  input logic                     cyc_stb_o,
  input logic signed [DATA_W-1:0] dem_data_o,
  input logic                     dem_valid_o
);
  localparam logic [CNT_W:0] HALF = (CNT_W+1)'(1) << (CNT_W - 1);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic         prev_exc;
  logic [CNT_W:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_exc <= 1'b0;
      run_len  <= '0;
    end else begin
      prev_exc <= exc_o;
      run_len  <= (exc_o != prev_exc) ? (CNT_W+1)'(1) : run_len + 1'b1;
    end
  end

  AST_EXC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (exc_o != prev_exc) |-> (run_len == HALF)); // R1
  AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(exc_o) |-> cyc_stb_o); // R2
  AST_STB_ONLY_FALL: assert property (@(posedge clk) disable iff (rst)
    cyc_stb_o |-> $fell(exc_o)); // R2
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && smp_data_i == '0) |=> (dem_data_o == '0)); // R3
  AST_MAGNITUDE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && smp_data_i != MOST_NEG) |=>
      (dem_data_o == $past(smp_data_i) || dem_data_o == -$past(smp_data_i))); // R3
  AST_NEG_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && smp_data_i == MOST_NEG && !exc_o && !quad_sel_i) |=>
      (dem_data_o == MOST_POS)); // R5
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    smp_valid_i |=> dem_valid_o); // R6
  AST_INVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_i |=> !dem_valid_o); // R6
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_i |=> $stable(dem_data_o)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!exc_o && !cyc_stb_o && !dem_valid_o && dem_data_o == '0)); // R9
endmodule

bind sync_demod_core sync_demod_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_data_i (smp_data_i),
  .smp_valid_i(smp_valid_i),
  .quad_sel_i (quad_sel_i),
  .exc_o      (exc_o),
  .cyc_stb_o  (cyc_stb_o),
  .dem_data_o (dem_data_o),
  .dem_valid_o(dem_valid_o)
);

// File: tb/test_sync_demod_core.sv
`timescale 1ns/1ps
module test_sync_demod_core;
  localparam int  CNT_W  = 10;
  localparam int  DATA_W = 16;
  localparam real TCLK   = 5.0;
  localparam logic signed [15:0] SMIN = 16'sh8000;
  localparam logic signed [15:0] SMAX = 16'sh7FFF;
  localparam int  AMP    = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] smp_data = '0;
  logic smp_valid = 1'b0;
  logic quad_sel  = 1'b0;
  logic exc, cyc_stb, dem_valid;
  logic signed [15:0] dem_data;

  int errors = 0;
  int checks = 0;

  logic [9:0] mcnt = '0;
  logic       exp_stb = 1'b0;

  always #(TCLK/2.0) clk = ~clk;

  always @(posedge clk) begin
    exp_stb <= !rst && (mcnt == 10'd1023);
    mcnt    <= rst ? 10'd0 : mcnt + 10'd1;
  end

  sync_demod_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_sync_demod_core (
    .clk(clk), .rst(rst), .smp_data_i(smp_data), .smp_valid_i(smp_valid),
    .quad_sel_i(quad_sel), .exc_o(exc), .cyc_stb_o(cyc_stb),
    .dem_data_o(dem_data), .dem_valid_o(dem_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic signed [15:0] f_exp(input logic signed [15:0] d,
                                                input logic [9:0] k, input logic q);
    logic [9:0] s;
    s = q ? k - 10'd256 : k;
    if (s[9]) return d;
    if (d == SMIN) return SMAX;
    return -d;
  endfunction

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1; smp_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 exc", exc, 0);
    chk("R9 strobe", cyc_stb, 0);
    chk("R9 valid", dem_valid, 0);
    chk("R9 data", dem_data, 0);
    rst = 1'b0;
  endtask

  task automatic t_excitation();
    int nstb = 0, nhigh = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      chk("R1 exc", exc, mcnt[9]);
      chk("R2 strobe", cyc_stb, exp_stb);
      nstb += cyc_stb;
      nhigh += exc;
    end
    chk("R2 strobe count", nstb, 2);
    chk("R1 duty", nhigh, 1024);
  endtask

  task automatic t_stream(input string req, input bit inv, input logic q);
    logic signed [15:0] pend, d, last;
    logic [9:0] k;
    longint sum = 0;
    int nchg = 0;
    @(negedge clk);
    while (mcnt != 10'd0) @(negedge clk);
    for (int i = 0; i <= 1024; i++) begin
      if (i > 0) begin
        chk(q ? "R4 sample" : "R3 sample", dem_data, pend);
        chk("R6 valid", dem_valid, 1);
        sum += dem_data;
        if (i > 1 && (dem_data < 0) != (last < 0)) nchg++;
        last = dem_data;
      end
      if (i < 1024) begin
        k = mcnt;
        d = (k[9] ^ inv) ? 16'(AMP) : -16'(AMP);
        pend = f_exp(d, k, q);
        smp_data = d; smp_valid = 1'b1; quad_sel = q;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
    if (q) begin
      chk({req, " quad sum"}, sum, 0);
      chk({req, " quad sign changes"}, nchg, 3);
    end else begin
      chk({req, " sum"}, sum, inv ? -1024*AMP : 1024*AMP);
      chk({req, " sign changes"}, nchg, 0);
    end
  endtask

  task automatic drive_one(input logic signed [15:0] d, input logic q);
    smp_data = d; smp_valid = 1'b1; quad_sel = q;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_saturate();
    @(negedge clk);
    while (!(mcnt < 10'd500)) @(negedge clk);
    drive_one(SMIN, 1'b0);
    chk("R5 min negated", dem_data, SMAX);
    drive_one(SMAX, 1'b0);
    chk("R5 max negated", dem_data, -SMAX);
    while (!(mcnt >= 10'd512 && mcnt < 10'd1000)) @(negedge clk);
    drive_one(SMIN, 1'b0);
    chk("R5 min passed", dem_data, SMIN);
    while (!(mcnt >= 10'd256 && mcnt < 10'd700)) @(negedge clk);
    drive_one(SMIN, 1'b1);
    chk("R5 R4 min negated quad", dem_data, SMAX);
  endtask

  task automatic t_valid_gap();
    @(negedge clk);
    while (!(mcnt >= 10'd512 && mcnt < 10'd1000)) @(negedge clk);
    drive_one(16'sd1234, 1'b0);
    chk("R6 valid high", dem_valid, 1);
    chk("R3 pass", dem_data, 1234);
    smp_data = 16'sd777;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 valid low", dem_valid, 0);
      chk("R7 hold", dem_data, 1234);
    end
    while (!(mcnt < 10'd500)) @(negedge clk);
    drive_one(16'sd77, 1'b0);
    chk("R3 negate", dem_data, -77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_excitation();
    t_stream("R8 in-phase", 1'b0, 1'b0);
    t_stream("R8 anti-phase", 1'b1, 1'b0);
    t_stream("R8 quadrature", 1'b0, 1'b1);
    t_saturate();
    t_valid_gap();
    t_reset_state();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(TCLK * 200000.0);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule